// File: doc/BRIEF.md
# Twin-Voice Sample Player with End-Marker Termination

This block plays back two independent streams of unsigned 8-bit samples held in an external byte memory and delivers one signed 8-bit value per voice. Software programs each voice through a small shared register window: writing a voice's volume register also aims the address registers at that voice. The start address is 25 bits wide and is loaded in three pieces. The write that carries the top piece also arms playback. A control register holds a master switch and one run bit per voice.

While a voice runs, a phase counter advanced by an external output-rate strobe decides when the next byte is due. Both voices share one memory read port. A round-robin arbiter drives that port with a valid/ready request and allows one read in flight. A returned byte equal to all-ones marks the end of the stream: the voice stops and drops its run bit. Any other byte is re-centred around zero, scaled by the voice's volume and held on the output until the next byte arrives.

Top module: `duo_pcm_player`

## Requirements
- R1: In the cycle after synchronous reset both sample outputs are 0, no memory request is valid, and the round-robin pointer favours voice 0 first.
- R2: A write to register 0 sets voice 0's volume and selects voice 0; a write to register 1 sets voice 1's volume and selects voice 1. Address writes go to the selected voice.
- R3: A write to register 2 takes bit 7 as the master switch, bit 4 as voice 0's run bit and bit 3 as voice 1's run bit. A voice is active only while the master switch, its run bit and its playing flag are all 1.
- R4: Register 3 loads address bits 13..6 from data 7..0 and clears bits 5..0. Register 4 loads bits 20..14 from data 6..0. Register 5 loads bits 24..21 from data 3..0, sets the playing flag, and clears the phase, the pending fetch and the held sample.
- R5: Writes to registers 3, 4 and 5 are ignored while the selected voice's run bit is 1, as it stood before the clock edge.
- R6: On each cycle with tick high and the voice active, the phase drops by 4. If it goes negative, 111 is added and one fetch becomes pending. A wrap that occurs while a fetch is already pending merges with it.
- R7: A request is valid when some voice has a pending fetch and no read is in flight. The address is that voice's current address. When both voices are waiting, the voice not granted last wins. The handshake clears that voice's pending fetch, and the next request waits for the response.
- R8: A returned byte b other than 0xFF increments the owning voice's address by one and sets its held sample to the low 8 bits of (b-128)*volume/128, with the division truncated toward zero.
- R9: A returned byte of 0xFF clears the owning voice's playing flag, run bit and pending fetch, and leaves its address unchanged.
- R10: Each sample output is registered. It shows the voice's held sample one cycle after a cycle in which the voice was active, and 0 one cycle after a cycle in which it was not.
- R11: When a register write and a response update the same field in one cycle, the register write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index (0..5) |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Output-rate strobe advancing the phase |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 25 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| smp_a | output | 8 | Voice 0 sample, two's complement |
| smp_b | output | 8 | Voice 1 sample, two's complement |

## Verification
A register write or response sampled at one edge changes voice state at that edge. The held sample reaches its output port one edge later, and a new request appears right after the edge that set the pending fetch. The bench's reference model updates at each rising edge from the pre-edge state, keeping the sample outputs one cycle behind it. At the following falling edge it compares both outputs, the request valid and the request address, so every due value is checked exactly in the cycle it is due. Short directed checks add the reset state, the first scaled value of a voice, silence after the end marker and silence while the master switch is off.

// File: rtl/duo_pcm_pkg.sv
package duo_pcm_pkg;
  localparam int ADDR_W   = 25;
  localparam int DATA_W   = 8;
  localparam int VOL_W    = 8;
  localparam int SMP_W    = 8;
  localparam int PERIOD   = 111;
  localparam int STEP     = 4;
  localparam int PH_W     = $clog2(PERIOD + 1) + 1;
  localparam int LO_LSB   = 6;
  localparam int MID_LSB  = 14;
  localparam int HI_LSB   = 21;
  localparam int MID_W    = HI_LSB - MID_LSB;
  localparam int HI_W     = ADDR_W - HI_LSB;
  localparam int GLB_BIT  = 7;
  localparam int RUN_BIT0 = 4;
  localparam int RUN_BIT1 = 3;
  localparam logic [DATA_W-1:0] END_MARK = '1;

  typedef enum logic [2:0] {
    RG_VOL0  = 3'd0,
    RG_VOL1  = 3'd1,
    RG_CTRL  = 3'd2,
    RG_AD_LO = 3'd3,
    RG_AD_MD = 3'd4,
    RG_AD_HI = 3'd5
  } reg_idx_e;

  // (b - 128) * v / 128, truncated toward zero, low bits kept
  function automatic logic [SMP_W-1:0] scale_sample(input logic [DATA_W-1:0] b,
                                                    input logic [VOL_W-1:0] v);
    logic signed [DATA_W+1:0] ctr;
    logic signed [18:0] prod;
    logic [18:0] mag;
    logic [18:0] res;
    ctr  = $signed({2'b00, b}) - $signed(10'd128);
    prod = $signed({{(19-DATA_W-2){ctr[DATA_W+1]}}, ctr}) * $signed({{(19-VOL_W){1'b0}}, v});
    mag  = prod[18] ? 19'(-prod) : 19'(prod);
    mag  = mag >> 7;
    res  = prod[18] ? 19'(-mag) : mag;
    return res[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/duo_pcm_voice.sv
module duo_pcm_voice
  import duo_pcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_on,
  input  logic              tick,
  input  logic              wr_vol,
  input  logic              wr_ctl,
  input  logic              ctl_bit,
  input  logic              wr_lo,
  input  logic              wr_mid,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              grant,
  input  logic              rsp_hit,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              want,
  output logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic [SMP_W-1:0]  sample
);
  logic [ADDR_W-1:0]     addr_q;
  logic [VOL_W-1:0]      vol_q;
  logic                  en_q, play_q, want_q;
  logic signed [PH_W-1:0] phase_q;
  logic signed [PH_W-1:0] ph_dec;
  logic [SMP_W-1:0]      cur_q;
  logic                  wrap;

  assign active = glb_on & en_q & play_q;
  assign ph_dec = phase_q - PH_W'(STEP);
  assign wrap   = ph_dec[PH_W-1];
  assign want   = want_q;
  assign addr   = addr_q;
  assign sample = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      vol_q   <= '0;
      en_q    <= 1'b0;
      play_q  <= 1'b0;
      want_q  <= 1'b0;
      phase_q <= '0;
      cur_q   <= '0;
    end else begin
      if (grant) want_q <= 1'b0;
      if (tick && active) begin
        phase_q <= wrap ? ph_dec + PH_W'(PERIOD) : ph_dec;
        if (wrap) want_q <= 1'b1;
      end
      if (rsp_hit) begin
        if (rsp_data == END_MARK) begin
          play_q <= 1'b0;
          en_q   <= 1'b0;
          want_q <= 1'b0;
        end else begin
          addr_q <= addr_q + ADDR_W'(1);
          cur_q  <= scale_sample(rsp_data, vol_q);
        end
      end
      if (wr_vol) vol_q <= wdata;
      if (wr_ctl) en_q <= ctl_bit;
      if (!en_q) begin
        if (wr_lo)  addr_q <= {addr_q[ADDR_W-1:MID_LSB], wdata, {LO_LSB{1'b0}}};
        if (wr_mid) addr_q <= {addr_q[ADDR_W-1:HI_LSB], wdata[MID_W-1:0], addr_q[MID_LSB-1:0]};
        if (wr_hi) begin
          addr_q  <= {wdata[HI_W-1:0], addr_q[HI_LSB-1:0]};
          play_q  <= 1'b1;
          phase_q <= '0;
          want_q  <= 1'b0;
          cur_q   <= '0;
        end
      end
    end
  end

  // R6: phase stays inside one period
  a_r6_phase_range: assert property (@(posedge clk) disable iff (rst)
    (phase_q >= 0) && (phase_q < PH_W'(PERIOD)));

  // R5: a running voice keeps its address except when a byte returns
  a_r5_addr_locked: assert property (@(posedge clk) disable iff (rst)
    (en_q && !rsp_hit) |=> $stable(addr_q));

  // R9: the end marker stops the voice
  a_r9_stop: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && rsp_data == END_MARK && !wr_ctl && !(wr_hi && !en_q)) |=> (!play_q && !en_q));
endmodule

// File: rtl/duo_pcm_arb.sv
module duo_pcm_arb
  import duo_pcm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             want,
  input  logic [1:0][ADDR_W-1:0] addrs,
  input  logic                   req_ready,
  input  logic                   rsp_valid,
  output logic                   req_valid,
  output logic [ADDR_W-1:0]      req_addr,
  output logic [1:0]             grant,
  output logic [1:0]             rsp_hit
);
  logic busy_q, owner_q, last_q;
  logic pick, hs;

  always_comb begin
    if (want[0] && want[1]) pick = ~last_q;
    else                    pick = want[1];
  end

  assign req_valid = (|want) & ~busy_q;
  assign req_addr  = addrs[pick];
  assign hs        = req_valid & req_ready;
  assign grant     = hs ? 2'(2'b01 << pick) : 2'b00;
  assign rsp_hit   = (rsp_valid && busy_q) ? 2'(2'b01 << owner_q) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      owner_q <= 1'b0;
      last_q  <= 1'b1;
    end else if (hs) begin
      busy_q  <= 1'b1;
      owner_q <= pick;
      last_q  <= pick;
    end else if (rsp_valid) begin
      busy_q  <= 1'b0;
    end
  end

  // R7: after a handshake no second request until the response
  a_r7_hold_off: assert property (@(posedge clk) disable iff (rst)
    hs |=> !req_valid);
endmodule

// File: rtl/duo_pcm_player.sv
module duo_pcm_player
  import duo_pcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [SMP_W-1:0]  smp_a,
  output logic [SMP_W-1:0]  smp_b
);
  localparam int NV = 2;

  logic                   sel_q, glb_q;
  logic [NV-1:0]          want, active, grant, rsp_hit;
  logic [NV-1:0][ADDR_W-1:0] addrs;
  logic [NV-1:0][SMP_W-1:0]  samples;
  logic [NV-1:0][SMP_W-1:0]  smp_q;
  logic                   wr_ctl, wr_lo, wr_mid, wr_hi;

  assign wr_ctl = wr_en && (wr_idx == 3'(RG_CTRL));
  assign wr_lo  = wr_en && (wr_idx == 3'(RG_AD_LO));
  assign wr_mid = wr_en && (wr_idx == 3'(RG_AD_MD));
  assign wr_hi  = wr_en && (wr_idx == 3'(RG_AD_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      glb_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_idx == 3'(RG_VOL0)) sel_q <= 1'b0;
      if (wr_idx == 3'(RG_VOL1)) sel_q <= 1'b1;
      if (wr_ctl)                glb_q <= wr_data[GLB_BIT];
    end
  end

  for (genvar v = 0; v < NV; v++) begin : g_voice
    localparam logic [2:0] VOL_IDX = (v == 0) ? 3'(RG_VOL0) : 3'(RG_VOL1);
    localparam int         RUN_POS = (v == 0) ? RUN_BIT0 : RUN_BIT1;
    logic is_sel;
    assign is_sel = (sel_q == 1'(v));

    duo_pcm_voice u_voice (
      .clk      (clk),
      .rst      (rst),
      .glb_on   (glb_q),
      .tick     (tick),
      .wr_vol   (wr_en && (wr_idx == VOL_IDX)),
      .wr_ctl   (wr_ctl),
      .ctl_bit  (wr_data[RUN_POS]),
      .wr_lo    (wr_lo && is_sel),
      .wr_mid   (wr_mid && is_sel),
      .wr_hi    (wr_hi && is_sel),
      .wdata    (wr_data),
      .grant    (grant[v]),
      .rsp_hit  (rsp_hit[v]),
      .rsp_data (mem_rsp_data),
      .want     (want[v]),
      .addr     (addrs[v]),
      .active   (active[v]),
      .sample   (samples[v])
    );

    always_ff @(posedge clk) begin
      if (rst) smp_q[v] <= '0;
      else     smp_q[v] <= active[v] ? samples[v] : '0;
    end

    // R10: an inactive voice is silent on the next cycle
    a_r10_silent: assert property (@(posedge clk) disable iff (rst)
      !active[v] |=> (smp_q[v] == '0));
  end

  duo_pcm_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .want      (want),
    .addrs     (addrs),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .req_valid (mem_req_valid),
    .req_addr  (mem_req_addr),
    .grant     (grant),
    .rsp_hit   (rsp_hit)
  );

  assign smp_a = smp_q[0];
  assign smp_b = smp_q[1];

  // R1: reset leaves the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mem_req_valid && smp_a == '0 && smp_b == '0));
endmodule

// File: tb/duo_pcm_player_test.sv
module duo_pcm_player_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int MEM_LAT    = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic        tick = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [24:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic [7:0]  smp_a, smp_b;

  duo_pcm_player uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .tick(tick), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .smp_a(smp_a), .smp_b(smp_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int end0 = -1, end1 = -1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int sample_at(input int a);
    int v;
    if (a == end0 || a == end1) return 255;
    v = (a * 29 + 7) & 255;
    if (v == 255) v = 254;
    return v;
  endfunction

  function automatic int scale_ref(input int b, input int vol);
    int q;
    q = ((b - 128) * vol) / 128;
    return q & 255;
  endfunction

  // ---------------- behavioural memory ----------------
  bit hs_q = 1'b0;
  int hs_a = 0, mem_cnt = 0, mem_pa = 0;
  always @(posedge clk) begin
    hs_q <= mem_req_valid && mem_req_ready;
    hs_a <= int'(mem_req_addr);
  end
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (mem_cnt == 1) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 8'(sample_at(mem_pa));
    end
    if (mem_cnt > 0) mem_cnt--;
    if (hs_q) begin
      mem_cnt = MEM_LAT;
      mem_pa  = hs_a;
    end
    mem_req_ready = (cyc % 3) != 1;
    tick          = (cyc % 2) == 0;
  end

  // ---------------- reference model ----------------
  int m_addr[2], m_vol[2], m_ph[2], m_cur[2], e_smp[2];
  bit m_en[2], m_play[2], m_want[2];
  bit m_glb, m_busy;
  int m_sel, m_owner, m_last;

  function automatic int m_pick();
    if (m_want[0] && m_want[1]) return (m_last == 0) ? 1 : 0;
    return m_want[1] ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_addr[i] = 0; m_vol[i] = 0; m_ph[i] = 0; m_cur[i] = 0; e_smp[i] = 0;
        m_en[i] = 0; m_play[i] = 0; m_want[i] = 0;
      end
      m_glb = 0; m_busy = 0; m_sel = 0; m_owner = 0; m_last = 1;
    end else begin
      bit oact[2];
      bit oen[2];
      int oaddr[2];
      int osel;
      bit v;
      int pk;
      int s;
      for (int i = 0; i < 2; i++) begin
        oact[i]  = m_glb && m_en[i] && m_play[i];
        oen[i]   = m_en[i];
        oaddr[i] = m_addr[i];
        e_smp[i] = oact[i] ? m_cur[i] : 0;
      end
      osel = m_sel;
      v  = (m_want[0] || m_want[1]) && !m_busy;
      pk = m_pick();
      if (v && mem_req_ready) begin
        m_busy = 1; m_owner = pk; m_last = pk; m_want[pk] = 0;
      end else if (mem_rsp_valid) begin
        m_busy = 0;
      end
      for (int i = 0; i < 2; i++)
        if (tick && oact[i]) begin
          m_ph[i] -= 4;
          if (m_ph[i] < 0) begin m_ph[i] += 111; m_want[i] = 1; end
        end
      if (mem_rsp_valid) begin
        if (mem_rsp_data == 8'hFF) begin
          m_play[m_owner] = 0; m_en[m_owner] = 0; m_want[m_owner] = 0;
        end else begin
          m_cur[m_owner]  = scale_ref(int'(mem_rsp_data), m_vol[m_owner]);
          m_addr[m_owner] = (m_addr[m_owner] + 1) & 32'h1FF_FFFF;
        end
      end
      if (wr_en) begin
        s = osel;
        case (wr_idx)
          3'd0: begin m_vol[0] = int'(wr_data); m_sel = 0; end
          3'd1: begin m_vol[1] = int'(wr_data); m_sel = 1; end
          3'd2: begin m_glb = wr_data[7]; m_en[0] = wr_data[4]; m_en[1] = wr_data[3]; end
          3'd3: if (!oen[s]) m_addr[s] = (oaddr[s] & 32'h1FF_C000) | (int'(wr_data) << 6);
          3'd4: if (!oen[s]) m_addr[s] = (oaddr[s] & 32'h1E0_3FFF) | ((int'(wr_data) & 127) << 14);
          3'd5: if (!oen[s]) begin
            m_addr[s] = (oaddr[s] & 32'h01F_FFFF) | ((int'(wr_data) & 15) << 21);
            m_play[s] = 1; m_ph[s] = 0; m_want[s] = 0; m_cur[s] = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      bit ev;
      int pk;
      chk(int'(smp_a) == e_smp[0], "R2 R3 R6 R8 R9 R10 R11 voice0 sample", int'(smp_a), e_smp[0]);
      chk(int'(smp_b) == e_smp[1], "R2 R3 R6 R8 R9 R10 R11 voice1 sample", int'(smp_b), e_smp[1]);
      ev = (m_want[0] || m_want[1]) && !m_busy;
      chk(mem_req_valid == ev, "R1 R6 R7 request valid", int'(mem_req_valid), int'(ev));
      if (ev) begin
        pk = m_pick();
        chk(int'(mem_req_addr) == m_addr[pk], "R4 R5 R7 request address",
            int'(mem_req_addr), m_addr[pk]);
      end
    end
    if (cyc > WD_LIMIT) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input int idx, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stop(input int ch);
    int n = 0;
    while (m_play[ch] && n < 20000) begin @(negedge clk); n++; end
    chk(!m_play[ch], "R9 playback ends at end marker", int'(m_play[ch]), 0);
  endtask

  int a0, a1;
  initial begin
    a0 = (1 << 21) | (5 << 14) | (8'h12 << 6);
    a1 = (3 << 21) | (8'h40 << 14) | (8'h2A << 6);
    end0 = a0 + 4;
    end1 = a1 + 6;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(smp_a == 8'd0 && smp_b == 8'd0, "R1 outputs after reset", int'({smp_a, smp_b}), 0);
    chk(!mem_req_valid, "R1 no request after reset", int'(mem_req_valid), 0);

    // voice 0 alone, unity volume
    wr(0, 128); wr(3, 8'h12); wr(4, 8'h05); wr(5, 8'h01);
    wr(2, 8'h90);
    idle(30);
    chk(int'(smp_a) == ((sample_at(a0) - 128) & 255), "R8 first scaled sample voice0",
        int'(smp_a), (sample_at(a0) - 128) & 255);
    wr(3, 8'h77);   // R5: ignored while running
    wr(5, 8'h0F);   // R5: no restart while running
    wait_stop(0);
    idle(2);
    chk(smp_a == 8'd0, "R9 voice0 silent after end marker", int'(smp_a), 0);

    // both voices, second with a wrapping volume
    wr(1, 200); wr(3, 8'h2A); wr(4, 8'h40); wr(5, 8'h03);
    wr(0, 64);  wr(3, 8'h12); wr(4, 8'h05); wr(5, 8'h01);
    wr(2, 8'h98);
    idle(120);
    wr(2, 8'h18);   // master switch off
    idle(3);
    chk(smp_a == 8'd0 && smp_b == 8'd0, "R3 silent with master switch off",
        int'({smp_a, smp_b}), 0);
    idle(100);
    wr(2, 8'h98);
    wait_stop(0);
    wait_stop(1);
    idle(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule